// File: doc/BRIEF.md
# Low-Side PWM Chopper with Overcurrent Latch

This block generates the low-side gate signal for a brushless DC motor commutator stage. A free-running 8-bit sawtooth counter is compared with a digital trip level to set the duty cycle of the low-side drivers. The trip level is picked up only when the ramp restarts, so a level change in the middle of a period never produces a runt pulse.

An overcurrent flag from an external comparator is watched on every clock. When it is seen, a latch is set and the gate is removed on the same edge. The latch is released only at a chopping event, which is either the restart of the ramp or a rising edge of the chop enable input, and only if the flag is low at that moment. Current-limit cycling therefore runs at the PWM rate. The enable input passes through a synchroniser and can itself act as the chop signal (trip level 0, enable toggled), or it can be held high so that the ramp restart releases the latch. A brake input forces the low-side gate on regardless of the latch, the enable and the trip level, so the windings are shorted for braking.

Top module: `lowside_chopper`

## Requirements
- R1: After synchronous reset the gate is low, the latch status is low, the ramp starts at 0 and the held trip level is all ones (zero duty) until the first ramp restart.
- R2: The ramp counts 0..255 and wraps to 0. The registered gate is high in the cycle after a cycle where the held trip level is below 255 and the ramp value is at or above it, so with a held trip T below 255 the gate is high 256-T cycles out of every 256.
- R3: A held trip level of 0 gives the gate high on every cycle; a held trip of 255 or more (9-bit input) gives the gate low on every cycle.
- R4: The trip input is sampled only on the edge that ends the cycle where the ramp is 255; trip changes at any other time have no effect on the gate until then.
- R5: Any clock edge that sees the overcurrent flag high sets the latch and drives the gate low on that same edge (brake low).
- R6: The latch clears only on an edge where a release event (ramp at 255, or an enable rising pulse) is present and the overcurrent flag is low; if the flag is high on that edge the latch stays set, and otherwise it holds.
- R7: The enable input passes through two synchroniser flops; its rising edge gives a one-cycle release pulse, and while the synchronised enable is low the gate is low (brake low).
- R8: Brake high drives the gate high on the next edge regardless of latch, enable and trip; the latch keeps updating underneath and takes effect again once brake falls.
- R9: With trip level 0 and the enable toggled as a chop signal, an overcurrent latch set while enable is high is released at the next enable rising pulse, before any ramp restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trip_level | input | 9 | Digital trip level compared with the ramp; 255 or more means zero duty |
| chop_en | input | 1 | Asynchronous chop enable; low disables the gate, rising edge releases the latch |
| oc_flag | input | 1 | Overcurrent flag from the external comparator, synchronous to clk |
| brake | input | 1 | Forces the low-side gate on |
| gate_lo | output | 1 | Registered low-side gate |
| oc_latched | output | 1 | Overcurrent latch status |

## Verification
The assertions take the overcurrent flag, brake and trip level to be synchronous to the clock, while the chop enable may arrive at any time and is only used after its synchroniser. The stimulus changes every input on the falling clock edge, holds the trip level over many ramp periods, and moves it in mid-period only to show that the change waits for the wrap. Overcurrent pulses are placed both clear of release events and overlapping a ramp restart, so the set-over-clear priority is exercised. Enable toggles are spaced well beyond the synchroniser depth so that each one yields exactly one release pulse.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [1:0] {
    SRC_OFF   = 2'd0,
    SRC_PWM   = 2'd1,
    SRC_BRAKE = 2'd2
  } gate_src_e;
endpackage

// File: rtl/lsc_ramp.sv
module lsc_ramp #(
  parameter int RAMP_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RAMP_W:0] trip_in,
  output logic            wrap_o,
  output logic            pwm_on_o
);
  localparam logic [RAMP_W-1:0] CNT_MAX  = {RAMP_W{1'b1}};
  localparam logic [RAMP_W:0]   TRIP_MAX = {1'b0, {RAMP_W{1'b1}}};

  logic [RAMP_W-1:0] cnt_q;
  logic [RAMP_W:0]   trip_q;

  assign wrap_o = (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      trip_q <= '1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (wrap_o) trip_q <= trip_in;
    end
  end

  assign pwm_on_o = (trip_q < TRIP_MAX) && ({1'b0, cnt_q} >= trip_q);

  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX) |=> (cnt_q == '0));
  p_count_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_trip_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !wrap_o |=> $stable(trip_q));
endmodule

// File: rtl/lsc_en_sync.sv
module lsc_en_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_async,
  output logic en_level_o,
  output logic en_rise_o
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b0;
    else     chain_q[0] <= en_async;
  end

  for (genvar g = 1; g < CHAIN; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[g] <= 1'b0;
      else     chain_q[g] <= chain_q[g-1];
    end
  end

  assign en_level_o = chain_q[STAGES-1];
  assign en_rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];

  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    en_rise_o |=> !en_rise_o);
endmodule

// File: rtl/lsc_oc_latch.sv
module lsc_oc_latch (
  input  logic clk,
  input  logic rst,
  input  logic oc_in,
  input  logic release_evt,
  output logic latch_next_o,
  output logic latched_o
);
  logic latch_q;

  always_comb begin
    if (oc_in)            latch_next_o = 1'b1;
    else if (release_evt) latch_next_o = 1'b0;
    else                  latch_next_o = latch_q;
  end

  always_ff @(posedge clk) begin
    if (rst) latch_q <= 1'b0;
    else     latch_q <= latch_next_o;
  end

  assign latched_o = latch_q;

  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (oc_in && release_evt) |=> latched_o);
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (latched_o && !release_evt) |=> latched_o);
  p_stay_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (!latched_o && !oc_in) |=> !latched_o);
endmodule

// File: rtl/lowside_chopper.sv
module lowside_chopper #(
  parameter int RAMP_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RAMP_W:0] trip_level,
  input  logic            chop_en,
  input  logic            oc_flag,
  input  logic            brake,
  output logic            gate_lo,
  output logic            oc_latched
);
  import lsc_pkg::*;

  logic      wrap, pwm_on, en_level, en_rise, latch_next, release_evt;
  gate_src_e src;
  logic      gate_q;

  lsc_ramp #(.RAMP_W(RAMP_W)) u_ramp (
    .clk      (clk),
    .rst      (rst),
    .trip_in  (trip_level),
    .wrap_o   (wrap),
    .pwm_on_o (pwm_on)
  );

  lsc_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .en_async   (chop_en),
    .en_level_o (en_level),
    .en_rise_o  (en_rise)
  );

  assign release_evt = wrap | en_rise;

  lsc_oc_latch u_latch (
    .clk          (clk),
    .rst          (rst),
    .oc_in        (oc_flag),
    .release_evt  (release_evt),
    .latch_next_o (latch_next),
    .latched_o    (oc_latched)
  );

  always_comb begin
    if (brake)                               src = SRC_BRAKE;
    else if (en_level && pwm_on && !latch_next) src = SRC_PWM;
    else                                     src = SRC_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= (src != SRC_OFF);
  end

  assign gate_lo = gate_q;

  p_oc_cut_r5: assert property (@(posedge clk) disable iff (rst)
    (oc_flag && !brake) |=> !gate_lo);
  p_brake_on_r8: assert property (@(posedge clk) disable iff (rst)
    brake |=> gate_lo);
  p_en_low_r7: assert property (@(posedge clk) disable iff (rst)
    (!en_level && !brake) |=> !gate_lo);
  p_latch_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (oc_latched && !release_evt && !brake) |=> !gate_lo);
endmodule

// File: tb/lowside_chopper_bench.sv
module lowside_chopper_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] trip_level = 9'd0;
  logic       chop_en = 1'b0;
  logic       oc_flag = 1'b0;
  logic       brake = 1'b0;
  logic       gate_lo, oc_latched;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  lowside_chopper u_lowside_chopper (
    .clk(clk), .rst(rst), .trip_level(trip_level), .chop_en(chop_en),
    .oc_flag(oc_flag), .brake(brake), .gate_lo(gate_lo), .oc_latched(oc_latched)
  );

  // behavioural reference model
  int m_ramp, m_trip;
  bit m_latch, m_gate;
  bit sq[3];

  always @(posedge clk) begin
    if (rst) begin
      m_ramp = 0; m_trip = 511; m_latch = 0; m_gate = 0;
      sq[0] = 0; sq[1] = 0; sq[2] = 0;
    end else begin
      bit wrap_now, rise_now, nl, pwm;
      wrap_now = (m_ramp == 255);
      rise_now = sq[1] && !sq[2];
      if (oc_flag) nl = 1;
      else if (wrap_now || rise_now) nl = 0;
      else nl = m_latch;
      pwm = (m_trip < 255) && (m_ramp >= m_trip);
      m_gate = brake || (sq[1] && pwm && !nl);
      m_latch = nl;
      if (wrap_now) m_trip = trip_level;
      m_ramp = (m_ramp + 1) % 256;
      sq[2] = sq[1]; sq[1] = sq[0]; sq[0] = chop_en;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check(cur_req, "gate_lo", gate_lo, m_gate);
      check(cur_req, "oc_latched", oc_latched, m_latch);
    end
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic duty(string req, int exp);
    int hi = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (gate_lo) hi++;
    end
    check(req, "duty count", hi, exp);
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    wait (cycles > 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 200000);
    finish_up();
  end

  initial begin
    run(5);
    check("R1", "reset gate", gate_lo, 0);
    check("R1", "reset latch", oc_latched, 0);
    rst = 1'b0;
    // R1: zero duty until first wrap even with enable and trip 0
    chop_en = 1'b1; trip_level = 9'd0;
    cur_req = "R1";
    run(200);
    check("R1", "gate before first wrap", gate_lo, 0);
    // R2: trip 64
    cur_req = "R2"; trip_level = 9'd64;
    run(600);
    duty("R2", 192);
    // R4: mid-period change
    cur_req = "R4";
    run(50);
    trip_level = 9'd200;
    run(3);
    trip_level = 9'd64;
    run(100);
    trip_level = 9'd200;
    run(600);
    duty("R4", 56);
    // R3: full and zero duty
    cur_req = "R3"; trip_level = 9'd0;
    run(300);
    duty("R3", 256);
    trip_level = 9'd255;
    run(300);
    duty("R3", 0);
    trip_level = 9'd300;
    run(300);
    duty("R3", 0);
    // R5 / R6: overcurrent with ramp release
    trip_level = 9'd0;
    run(300);
    cur_req = "R5";
    oc_flag = 1'b1;
    run(1);
    check("R5", "gate cut", gate_lo, 0);
    check("R5", "latch set", oc_latched, 1);
    run(2);
    oc_flag = 1'b0;
    cur_req = "R6";
    run(3);
    check("R6", "latch held after flag low", oc_latched, 1);
    run(600);
    // R6: flag held high across a ramp restart
    oc_flag = 1'b1;
    run(400);
    check("R6", "latch kept with flag high", oc_latched, 1);
    oc_flag = 1'b0;
    run(600);
    // R7: enable low gates off
    cur_req = "R7";
    chop_en = 1'b0;
    run(10);
    check("R7", "gate with enable low", gate_lo, 0);
    chop_en = 1'b1;
    run(10);
    check("R7", "gate with enable high", gate_lo, 1);
    // R9: enable as chop signal
    cur_req = "R9";
    for (int k = 0; k < 20; k++) begin
      run(20);
      if (k % 3 == 1) begin
        oc_flag = 1'b1; run(2); oc_flag = 1'b0;
      end
      run(10);
      chop_en = 1'b0;
      run(20);
      chop_en = 1'b1;
    end
    run(5);
    oc_flag = 1'b1; run(1); oc_flag = 1'b0;
    run(5);
    chop_en = 1'b0; run(10); chop_en = 1'b1;
    run(4);
    check("R9", "latch released by enable edge", oc_latched, 0);
    // R8: brake overrides latch and enable
    cur_req = "R8";
    oc_flag = 1'b1; chop_en = 1'b0; brake = 1'b1;
    run(5);
    check("R8", "gate under brake", gate_lo, 1);
    check("R8", "latch under brake", oc_latched, 1);
    oc_flag = 1'b0;
    run(300);
    brake = 1'b0;
    run(5);
    chop_en = 1'b1;
    run(600);
    finish_up();
  end
endmodule